// File: doc/BRIEF.md
# Processor Exception Entry Controller

This block takes the exception requests a processor core raises and picks one of them by a fixed priority. It then carries out the whole entry into the privileged mode of that exception in one clock edge. The return link and the old status word go into the register bank of the target mode. The status word gets the new mode number, the 32-bit instruction state and the interrupt masks. The program counter is redirected to the exception's vector. When the handler returns, one strobe reloads the program counter from the banked link minus the offset that suits the exception. The same strobe restores the saved status word.

The surrounding core keeps the live status register and the program counter. It presents both as inputs every cycle. Whenever `redirect` is high, it loads `pc_out` and `psr_out`. The banked link and saved-status values are kept inside the block, one bank per privileged mode. Each entry also shows them on the `bank_*` outputs. The mask bits work like this: a fast interrupt is accepted only while status bit 6 is clear, and a normal interrupt only while status bit 7 is clear.

Top module: `exc_entry_ctrl`

## Requirements
- R1: Request codes and priority, highest first: reset, data abort, fast interrupt, normal interrupt, prefetch abort, undefined instruction, software interrupt. When several accepted requests are present in a cycle, only the highest one is taken. The next cycle shows `entry`=1 and `redirect`=1. With no accepted request, `entry` stays 0.
- R2: On entry, `bank_lr` shows the `pc_in` value of the taking cycle. That value is stored as the link of the target mode's bank.
- R3: On entry, `bank_psr` shows the `cpsr_in` value of the taking cycle. That value is stored as the saved status of the target mode's bank.
- R4: On entry, `psr_out[4:0]` and `bank_mode` carry the target mode: 10001 fast interrupt, 10010 normal interrupt, 10011 reset and software interrupt, 10111 both aborts, 11011 undefined. `pc_out` is VBASE plus the vector offset: reset 0x00, undefined 0x04, software 0x08, prefetch abort 0x0C, data abort 0x10, normal interrupt 0x18, fast interrupt 0x1C.
- R5: On entry, `psr_out[5]` is 0 and `psr_out[7]` is 1. `psr_out[DW-1:8]` equals `cpsr_in[DW-1:8]`.
- R6: On entry, `psr_out[6]` is 1 for reset and fast interrupt. For every other exception it equals `cpsr_in[6]`.
- R7: A fast interrupt request is ignored while `cpsr_in[6]`=1, and a normal interrupt request while `cpsr_in[7]`=1. A lower-priority request can then be taken.
- R8: `exc_ret` with `cpsr_in[4:0]` naming a banked mode redirects the next cycle with `entry`=0. `pc_out` is then the bank's link minus an offset: 4 for normal interrupt, fast interrupt and prefetch abort, 8 for data abort, 0 for reset, software interrupt and undefined. `psr_out` is the bank's saved status.
- R9: `exc_ret` while `cpsr_in[4:0]` names no banked mode (for example 10000) is ignored: `redirect` stays 0.
- R10: If an accepted request and `exc_ret` arrive in the same cycle, the entry is taken and the return is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the block's registers |
| req_rst | input | 1 | Reset exception request |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| pc_in | input | AW | Address of the next instruction (return link) |
| cpsr_in | input | DW | Current status register |
| exc_ret | input | 1 | Exception return strobe |
| redirect | output | 1 | Load `pc_out` and `psr_out` this cycle |
| entry | output | 1 | The redirect is an exception entry (0: a return) |
| pc_out | output | AW | New program counter |
| psr_out | output | DW | New status register |
| bank_mode | output | 5 | Mode whose bank was written on entry |
| bank_lr | output | AW | Link value written on entry |
| bank_psr | output | DW | Saved status written on entry |

## Verification
The assertions check these rules on every cycle:
- every entry copies the sampled program counter and status word into the bank outputs;
- every entry clears the state bit and sets the normal-interrupt mask;
- entries other than reset and fast interrupt keep the fast-interrupt mask;
- a normal-interrupt entry never follows a masked status word;
- a return only follows a return strobe in a banked mode;
- a reset request is always taken.

The exact vector, mode number and priority winner for every request pattern and mask combination can only be shown by the bench's sweep. The same holds for the per-exception return offset, which tells the two aborts apart inside one bank. The dropping of a return that arrives with an entry is also shown only there.

// File: rtl/exc_pkg.sv
package exc_pkg;

    typedef enum logic [2:0] {
        EK_RST  = 3'd0,
        EK_DABT = 3'd1,
        EK_FIQ  = 3'd2,
        EK_IRQ  = 3'd3,
        EK_PABT = 3'd4,
        EK_UND  = 3'd5,
        EK_SWI  = 3'd6
    } exc_kind_e;

    localparam int NKIND = 7;
    localparam int NBANK = 5;
    localparam int BIW   = $clog2(NBANK);

    localparam logic [4:0] MODE_FIQ = 5'b10001;
    localparam logic [4:0] MODE_IRQ = 5'b10010;
    localparam logic [4:0] MODE_SVC = 5'b10011;
    localparam logic [4:0] MODE_ABT = 5'b10111;
    localparam logic [4:0] MODE_UND = 5'b11011;

    typedef struct packed {
        logic           hit;
        logic [BIW-1:0] idx;
    } bank_sel_t;

    function automatic logic [4:0] kind_mode(exc_kind_e k);
        case (k)
            EK_FIQ:          return MODE_FIQ;
            EK_IRQ:          return MODE_IRQ;
            EK_DABT, EK_PABT: return MODE_ABT;
            EK_UND:          return MODE_UND;
            default:         return MODE_SVC;
        endcase
    endfunction

    function automatic logic [7:0] kind_vector(exc_kind_e k);
        case (k)
            EK_RST:  return 8'h00;
            EK_UND:  return 8'h04;
            EK_SWI:  return 8'h08;
            EK_PABT: return 8'h0C;
            EK_DABT: return 8'h10;
            EK_IRQ:  return 8'h18;
            default: return 8'h1C;
        endcase
    endfunction

    function automatic logic [3:0] kind_ret_off(exc_kind_e k);
        case (k)
            EK_IRQ, EK_FIQ, EK_PABT: return 4'd4;
            EK_DABT:                 return 4'd8;
            default:                 return 4'd0;
        endcase
    endfunction

    function automatic bank_sel_t mode_bank(logic [4:0] m);
        bank_sel_t b;
        b.hit = 1'b1;
        case (m)
            MODE_FIQ: b.idx = BIW'(0);
            MODE_IRQ: b.idx = BIW'(1);
            MODE_SVC: b.idx = BIW'(2);
            MODE_ABT: b.idx = BIW'(3);
            MODE_UND: b.idx = BIW'(4);
            default: begin
                b.hit = 1'b0;
                b.idx = '0;
            end
        endcase
        return b;
    endfunction

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter #(
    parameter int NREQ = 7,
    localparam int SW  = $clog2(NREQ)
) (
    input  logic [NREQ-1:0] req,
    output logic            any,
    output logic [SW-1:0]   sel
);
    // Index 0 is the highest priority: scan from the lowest upward so the
    // last assignment is the winner.
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = NREQ - 1; i >= 0; i--) begin
            if (req[i]) begin
                any = 1'b1;
                sel = SW'(i);
            end
        end
    end
endmodule

// File: rtl/exc_lookup.sv
module exc_lookup
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter logic [AW-1:0] VBASE = '0
) (
    input  exc_kind_e       kind,
    output logic [4:0]      mode,
    output logic [AW-1:0]   vec,
    output logic            set_fmask
);
    always_comb begin
        mode      = kind_mode(kind);
        vec       = VBASE + AW'(kind_vector(kind));
        set_fmask = (kind == EK_RST) || (kind == EK_FIQ);
    end
endmodule

// File: rtl/exc_bank.sv
module exc_bank
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           we,
    input  logic [BIW-1:0] widx,
    input  logic [AW-1:0]  wlr,
    input  logic [DW-1:0]  wpsr,
    input  exc_kind_e      wkind,
    input  logic [BIW-1:0] ridx,
    output logic [AW-1:0]  rlr,
    output logic [DW-1:0]  rpsr,
    output exc_kind_e      rkind
);
    typedef struct packed {
        logic [AW-1:0] lr;
        logic [DW-1:0] psr;
        exc_kind_e     kind;
    } bank_ent_t;

    bank_ent_t ent_q [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        bank_ent_t ent_d;
        always_comb begin
            ent_d = ent_q[b];
            if (we && (widx == BIW'(b))) begin
                ent_d.lr   = wlr;
                ent_d.psr  = wpsr;
                ent_d.kind = wkind;
            end
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ent_q[b] <= '{lr: '0, psr: '0, kind: EK_RST};
            else        ent_q[b] <= ent_d;
        end
    end

    always_comb begin
        rlr   = '0;
        rpsr  = '0;
        rkind = EK_RST;
        for (int b = 0; b < NBANK; b++) begin
            if (ridx == BIW'(b)) begin
                rlr   = ent_q[b].lr;
                rpsr  = ent_q[b].psr;
                rkind = ent_q[b].kind;
            end
        end
    end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32,
    parameter logic [AW-1:0] VBASE = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_rst,
    input  logic          req_dabt,
    input  logic          req_fiq,
    input  logic          req_irq,
    input  logic          req_pabt,
    input  logic          req_und,
    input  logic          req_swi,
    input  logic [AW-1:0] pc_in,
    input  logic [DW-1:0] cpsr_in,
    input  logic          exc_ret,
    output logic          redirect,
    output logic          entry,
    output logic [AW-1:0] pc_out,
    output logic [DW-1:0] psr_out,
    output logic [4:0]    bank_mode,
    output logic [AW-1:0] bank_lr,
    output logic [DW-1:0] bank_psr
);
    localparam int KW = $clog2(NKIND);

    typedef struct packed {
        logic          redirect;
        logic          entry;
        logic [AW-1:0] pc;
        logic [DW-1:0] psr;
        logic [4:0]    bmode;
        logic [AW-1:0] blr;
        logic [DW-1:0] bpsr;
    } ctl_t;

    ctl_t st_d, st_q;

    logic [NKIND-1:0] acc_req;
    logic             take;
    logic [KW-1:0]    sel_raw;
    exc_kind_e        sel_kind;
    logic [4:0]       tgt_mode;
    logic [AW-1:0]    tgt_vec;
    logic             tgt_fmask;
    bank_sel_t        wsel, rsel;
    logic [AW-1:0]    rd_lr;
    logic [DW-1:0]    rd_psr;
    exc_kind_e        rd_kind;

    always_comb begin
        acc_req = {req_swi, req_und, req_pabt,
                   req_irq & ~cpsr_in[7],
                   req_fiq & ~cpsr_in[6],
                   req_dabt, req_rst};
        sel_kind = exc_kind_e'(sel_raw);
        wsel     = mode_bank(tgt_mode);
        rsel     = mode_bank(cpsr_in[4:0]);
    end

    exc_arbiter #(.NREQ(NKIND)) u_arb (
        .req (acc_req),
        .any (take),
        .sel (sel_raw)
    );

    exc_lookup #(.AW(AW), .VBASE(VBASE)) u_lut (
        .kind      (sel_kind),
        .mode      (tgt_mode),
        .vec       (tgt_vec),
        .set_fmask (tgt_fmask)
    );

    exc_bank #(.AW(AW), .DW(DW)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (take),
        .widx  (wsel.idx),
        .wlr   (pc_in),
        .wpsr  (cpsr_in),
        .wkind (sel_kind),
        .ridx  (rsel.idx),
        .rlr   (rd_lr),
        .rpsr  (rd_psr),
        .rkind (rd_kind)
    );

    always_comb begin
        st_d          = st_q;
        st_d.redirect = 1'b0;
        st_d.entry    = 1'b0;
        if (take) begin
            st_d.redirect = 1'b1;
            st_d.entry    = 1'b1;
            st_d.pc       = tgt_vec;
            st_d.psr      = cpsr_in;
            st_d.psr[4:0] = tgt_mode;
            st_d.psr[5]   = 1'b0;
            st_d.psr[7]   = 1'b1;
            if (tgt_fmask) st_d.psr[6] = 1'b1;
            st_d.bmode    = tgt_mode;
            st_d.blr      = pc_in;
            st_d.bpsr     = cpsr_in;
        end else if (exc_ret && rsel.hit) begin
            st_d.redirect = 1'b1;
            st_d.pc       = rd_lr - AW'(kind_ret_off(rd_kind));
            st_d.psr      = rd_psr;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign redirect  = st_q.redirect;
    assign entry     = st_q.entry;
    assign pc_out    = st_q.pc;
    assign psr_out   = st_q.psr;
    assign bank_mode = st_q.bmode;
    assign bank_lr   = st_q.blr;
    assign bank_psr  = st_q.bpsr;
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
    import exc_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          req_rst,
    input logic          req_irq,
    input logic [AW-1:0] pc_in,
    input logic [DW-1:0] cpsr_in,
    input logic          exc_ret,
    input logic          redirect,
    input logic          entry,
    input logic [DW-1:0] psr_out,
    input logic [4:0]    bank_mode,
    input logic [AW-1:0] bank_lr,
    input logic [DW-1:0] bank_psr
);
    p_entry_redirects_r1: assert property (@(posedge clk) disable iff (!rst_n)
        entry |-> redirect);

    p_link_saved_r2: assert property (@(posedge clk) disable iff (!rst_n)
        entry |-> bank_lr == $past(pc_in));

    p_status_saved_r3: assert property (@(posedge clk) disable iff (!rst_n)
        entry |-> bank_psr == $past(cpsr_in));

    p_mode_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        entry |-> psr_out[4:0] == bank_mode);

    p_state_masks_r5: assert property (@(posedge clk) disable iff (!rst_n)
        entry |-> (!psr_out[5] && psr_out[7]
                   && psr_out[DW-1:8] == $past(cpsr_in[DW-1:8])));

    p_fmask_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && (bank_mode == MODE_IRQ || bank_mode == MODE_ABT
                   || bank_mode == MODE_UND))
        |-> psr_out[6] == $past(cpsr_in[6]));

    p_irq_masked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && bank_mode == MODE_IRQ) |-> !$past(cpsr_in[7]));

    p_ret_source_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (redirect && !entry) |->
            ($past(exc_ret) && $past(mode_bank(cpsr_in[4:0]).hit)));

    p_reset_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(req_rst) |-> (entry && bank_mode == MODE_SVC));

    p_irq_no_reset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (entry && bank_mode == MODE_IRQ) |-> ($past(req_irq) && !$past(req_rst)));
endmodule

bind exc_entry_ctrl exc_entry_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_rst   (req_rst),
    .req_irq   (req_irq),
    .pc_in     (pc_in),
    .cpsr_in   (cpsr_in),
    .exc_ret   (exc_ret),
    .redirect  (redirect),
    .entry     (entry),
    .psr_out   (psr_out),
    .bank_mode (bank_mode),
    .bank_lr   (bank_lr),
    .bank_psr  (bank_psr)
);

// File: tb/sim_exc_entry_ctrl.sv
`timescale 1ns/1ps
module sim_exc_entry_ctrl;
    localparam int AW = 32;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [6:0] req = '0;
    logic [AW-1:0] pc_in = '0;
    logic [DW-1:0] cpsr_in = '0;
    logic exc_ret = 1'b0;
    logic redirect, entry;
    logic [AW-1:0] pc_out, bank_lr;
    logic [DW-1:0] psr_out, bank_psr;
    logic [4:0] bank_mode;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    exc_entry_ctrl #(.AW(AW), .DW(DW)) u0 (
        .clk(clk), .rst_n(rst_n),
        .req_rst(req[0]), .req_dabt(req[1]), .req_fiq(req[2]), .req_irq(req[3]),
        .req_pabt(req[4]), .req_und(req[5]), .req_swi(req[6]),
        .pc_in(pc_in), .cpsr_in(cpsr_in), .exc_ret(exc_ret),
        .redirect(redirect), .entry(entry), .pc_out(pc_out), .psr_out(psr_out),
        .bank_mode(bank_mode), .bank_lr(bank_lr), .bank_psr(bank_psr)
    );

    task automatic chk(string tag, logic [127:0] act, logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Request codes 0..6 follow R1; mode numbers and vectors follow R4.
    function automatic logic [4:0] e_mode(int k);
        case (k)
            2: return 5'b10001;
            3: return 5'b10010;
            1, 4: return 5'b10111;
            5: return 5'b11011;
            default: return 5'b10011;
        endcase
    endfunction
    function automatic logic [31:0] e_vec(int k);
        case (k)
            0: return 32'h00; 5: return 32'h04; 6: return 32'h08;
            4: return 32'h0C; 1: return 32'h10; 3: return 32'h18;
            default: return 32'h1C;
        endcase
    endfunction
    function automatic logic [31:0] e_off(int k);   // R8
        case (k)
            2, 3, 4: return 32'd4;
            1: return 32'd8;
            default: return 32'd0;
        endcase
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 reset state", {redirect, entry, pc_out, psr_out}, '0);
        rst_n = 1'b1;

        // R1 R4 R5 R6 R7: sweep every request pattern against every mask pair.
        for (int m = 0; m < 4; m++) begin
            for (int r = 0; r < 128; r++) begin
                logic [6:0] acc;
                int k;
                logic [31:0] cin, pin, ep;
                string tg;
                cin = {24'hC3A55A ^ 24'(r * 977), m[1], m[0], r[0], 5'b10000};
                pin = 32'h1000_0000 + 32'((m * 128 + r) * 4);
                acc = 7'(r);
                if (m[0]) acc[2] = 1'b0;
                if (m[1]) acc[3] = 1'b0;
                k = -1;
                for (int i = 6; i >= 0; i--) if (acc[i]) k = i;
                req = 7'(r); cpsr_in = cin; pc_in = pin;
                @(negedge clk);
                tg = (acc != 7'(r)) ? "R7 masked request" : "R1 priority";
                if (k < 0) begin
                    chk(tg, {redirect, entry}, 2'b00);
                end else begin
                    ep = cin;
                    ep[4:0] = e_mode(k);
                    ep[5] = 1'b0;
                    ep[7] = 1'b1;
                    if (k == 0 || k == 2) ep[6] = 1'b1;
                    chk(tg, {redirect, entry, bank_mode}, {2'b11, e_mode(k)});
                    chk("R4 vector", pc_out, e_vec(k));
                    chk("R2 link", bank_lr, pin);
                    chk("R3 saved status", bank_psr, cin);
                    chk((k == 0 || k == 2) ? "R6 fmask set" : "R5 R6 status",
                        psr_out, ep);
                end
            end
        end

        // R8: enter each kind from user mode, then return from its bank.
        for (int k = 0; k < 7; k++) begin
            logic [31:0] cin, pin;
            cin = {24'h5E0000 + 24'(k), 3'b000, 5'b10000};
            pin = 32'h2000_0100 + 32'(k * 64);
            req = 7'(1 << k); cpsr_in = cin; pc_in = pin;
            @(negedge clk);
            req = '0; cpsr_in = psr_out; exc_ret = 1'b1; pc_in = 32'hDEAD_0000;
            @(negedge clk);
            chk("R8 return strobe", {redirect, entry}, 2'b10);
            chk("R8 return pc", pc_out, pin - e_off(k));
            chk("R8 restored status", psr_out, cin);
            exc_ret = 1'b0;
        end

        // R9: return strobe from a mode with no bank.
        cpsr_in = 32'h0000_0010; exc_ret = 1'b1;
        @(negedge clk);
        chk("R9 ignored return", {redirect, entry}, 2'b00);
        cpsr_in = 32'h0000_001F;
        @(negedge clk);
        chk("R9 ignored return sys", {redirect, entry}, 2'b00);

        // R10: entry and return together; entry wins.
        cpsr_in = 32'h0000_0013; req = 7'b000_1000; pc_in = 32'h3000_0040;
        @(negedge clk);
        chk("R10 entry wins", {redirect, entry, bank_mode, pc_out},
            {2'b11, 5'b10010, 32'h18});
        chk("R10 link", bank_lr, 32'h3000_0040);
        req = '0; exc_ret = 1'b0;
        @(negedge clk);
        chk("R10 single cycle", {redirect, entry}, 2'b00);

        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule